// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the two least significant address bits for a four-beat burst into a synchronous memory. When a burst starts, the block captures the two starting address bits and resets its beat index. On every later rising edge where the active-low advance qualifier is sampled low, it steps to the next beat. The sequence wraps inside the aligned group of four words.

A static ordering strap selects one of two sequences. In interleaved order, each address is the start bits XORed with the beat index. In linear order, each address is the start bits plus the beat index, modulo four. The upper address bits, the storage array and chip-select decoding belong to the surrounding logic. That logic asserts the load strobe whenever it accepts an address strobe.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high on a rising edge) clears the captured start bits and the beat index. After reset, `addr_o` and `beat_o` both read 0.
- R2: A rising edge with `load_i` high captures `start_i` and sets the beat index to 0. From the next cycle, `beat_o` is 0 and `addr_o` equals the captured start bits in either order.
- R3: After a burst has been loaded, a rising edge with `adv_n_i` low and `load_i` low advances `beat_o` by one, modulo 4.
- R4: A rising edge with `adv_n_i` high and `load_i` low leaves `beat_o` and `addr_o` unchanged.
- R5: With `mode_i` high (interleaved order), `addr_o` equals the captured start bits XOR `beat_o`.
- R6: With `mode_i` low (linear order), `addr_o` equals the captured start bits plus `beat_o`, modulo 4.
- R7: When `load_i` is high and `adv_n_i` is low on the same edge, the load wins. `beat_o` becomes 0 and `addr_o` becomes the new start bits.
- R8: Between reset and the first load there is no burst, and `adv_n_i` low has no effect. `beat_o` and `addr_o` stay 0.
- R9: After four advances from a load, `addr_o` returns to the captured start bits and `beat_o` returns to 0.
- R10: `mode_i` is a static strap. It may change only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Burst start: capture `start_i` |
| start_i | input | 2 | Starting low address bits |
| adv_n_i | input | 1 | Advance qualifier, active low |
| mode_i | input | 1 | Order strap: 1 interleaved, 0 linear |
| addr_o | output | 2 | Current burst low address bits |
| beat_o | output | 2 | Beat index within the burst |

## Verification
The bench sweeps every start value in both orders and walks each burst past its wrap point, so it covers both the XOR and the modular-add paths. A mapping that confused the two orders, or carried out of two bits, would print a wrong address on some beat.

Holds are interleaved between the advances. A design that advanced on the wrong polarity of the qualifier would drift during those holds.

The bench also drives a load and an advance on the same edge. A design that let the advance win would start its new burst at beat 1. Finally, it sends advances before any load. A design with no notion of an idle state would start counting from reset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst ordering selected by the strap input
    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] start_i,
    output logic [W-1:0] start_o
);

    typedef struct packed {
        logic [W-1:0] start;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.start = start_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_o = st_q.start;

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         adv_n_i,
    output logic [W-1:0] beat_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic         active;
        logic [W-1:0] beat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // A new burst always restarts at beat zero, even if advance is low
            st_d.active = 1'b1;
            st_d.beat   = '0;
        end else if (st_q.active && !adv_n_i) begin
            // Natural wrap of the W-bit counter keeps the group aligned
            st_d.beat = st_q.beat + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.beat;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] beat_i,
    input  order_e       order_i,
    output logic [W-1:0] addr_o
);

    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVED: addr_o = start_i ^ beat_i;
            default:         addr_o = start_i + beat_i;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic [BURST_BITS-1:0] start_i,
    input  logic                  adv_n_i,
    input  logic                  mode_i,
    output logic [BURST_BITS-1:0] addr_o,
    output logic [BURST_BITS-1:0] beat_o
);

    localparam int W = BURST_BITS;

    logic [W-1:0] start_q;
    logic [W-1:0] beat_q;
    order_e       order;

    assign order = order_e'(mode_i);

    burst_start_reg #(.W(W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (start_i),
        .start_o (start_q)
    );

    burst_beat_ctr #(.W(W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat_q)
    );

    burst_order_map #(.W(W)) u_map (
        .start_i (start_q),
        .beat_i  (beat_q),
        .order_i (order),
        .addr_o  (addr_o)
    );

    assign beat_o = beat_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int W = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         load_i,
    input logic [W-1:0] start_i,
    input logic         adv_n_i,
    input logic         mode_i,
    input logic [W-1:0] addr_o,
    input logic [W-1:0] beat_o
);

    // Independent tracking of the burst start and of whether a burst exists
    logic [W-1:0] cap_q;
    logic         seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            seen_q <= 1'b0;
        end else if (load_i) begin
            cap_q  <= start_i;
            seen_q <= 1'b1;
        end
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (beat_o == '0 && addr_o == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (beat_o == '0 && addr_o == $past(start_i)));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !load_i && !adv_n_i) |=> (beat_o == W'($past(beat_o) + W'(1))));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=> ($stable(beat_o) && $stable(addr_o)));

    p_ilv_r5: assert property (@(posedge clk) disable iff (rst)
        mode_i |-> (addr_o == (cap_q ^ beat_o)));

    p_lin_r6: assert property (@(posedge clk) disable iff (rst)
        !mode_i |-> (addr_o == W'(cap_q + beat_o)));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && !load_i) |=> (beat_o == '0 && addr_o == '0));

    p_static_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_i));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.W(BURST_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .start_i (start_i),
    .adv_n_i (adv_n_i),
    .mode_i  (mode_i),
    .addr_o  (addr_o),
    .beat_o  (beat_o)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [1:0] start_i = 2'd0;
    logic       adv_n_i = 1'b1;
    logic       mode_i = 1'b0;
    logic [1:0] addr_o;
    logic [1:0] beat_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    // Bench model state
    int  m_start = 0;
    int  m_beat  = 0;
    bit  m_active = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq u_burst_addr_seq (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (start_i),
        .adv_n_i (adv_n_i),
        .mode_i  (mode_i),
        .addr_o  (addr_o),
        .beat_o  (beat_o)
    );

    function automatic int exp_addr();
        if (mode_i) return (m_start ^ m_beat) & 3;
        return (m_start + m_beat) % 4;
    endfunction

    task automatic check(input string tag);
        int ea;
        ea = exp_addr();
        n_cmp++;
        if (int'(addr_o) != ea || int'(beat_o) != m_beat) begin
            n_bad++;
            $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
                     tag, addr_o, beat_o, ea, m_beat);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; load_i = 1'b0; adv_n_i = 1'b1; mode_i = mode;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_start = 0; m_beat = 0; m_active = 1'b0;
        #1;
    endtask

    task automatic step(input logic ld, input logic [1:0] st, input logic advn);
        @(negedge clk);
        load_i = ld; start_i = st; adv_n_i = advn;
        @(posedge clk);
        if (ld) begin
            m_start = int'(st); m_beat = 0; m_active = 1'b1;
        end else if (m_active && !advn) begin
            m_beat = (m_beat + 1) % 4;
        end
        #1;
        load_i = 1'b0; adv_n_i = 1'b1;
    endtask

    initial begin
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                do_reset(logic'(md));
                check("R1 reset state");
                step(1'b0, 2'd0, 1'b0);
                check("R8 advance before load");
                step(1'b0, 2'd0, 1'b0);
                check("R8 advance before load");
                step(1'b1, 2'(s), 1'b1);
                check("R2 load");
                for (int k = 1; k <= 5; k++) begin
                    step(1'b0, 2'(3 - s), 1'b0);
                    if (md == 1) check("R3 R5 interleaved step");
                    else         check("R3 R6 linear step");
                    if (k == 4) check("R9 wrap to start");
                    step(1'b0, 2'(s), 1'b1);
                    check("R4 hold");
                end
                step(1'b1, 2'(s ^ 2), 1'b0);
                check("R7 load beats advance");
                step(1'b0, 2'd0, 1'b0);
                if (md == 1) check("R5 step after reload");
                else         check("R6 step after reload");
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule